// File: doc/BRIEF.md
# I2C Status Word and Interrupt Flag Unit

This block holds the eight-bit status word that a host reads from a two-wire serial controller, and it drives that controller's single level interrupt request. A separate bit and byte engine, which is not part of this block, watches the clock and data lines. It reports single-cycle event pulses: an address match, a general-call match, a byte finished in master or slave role, a stop, the start of a transfer, lost arbitration, and a sampled acknowledge bit. It also reports three level signals for its current role and the bus state. The unit qualifies each event against the acknowledge-enable and general-call-enable configuration bits, and against its own record of whether the device is the addressed slave. From that it keeps the sticky flags and the interrupt flag.

The host reads the status word to find out why the interrupt fired. It raises a one-cycle read strobe with each read. That strobe clears the interrupt flag, and nothing else in the word changes. The word has no write path. A new qualifying event that arrives in the same cycle as a read wins, so no event is lost.

The general-call logic can be removed with a parameter. The bit 7 flag then stays at 0.

Top module: `twi_status_flags`

## Requirements
- R1: After reset the status word and the interrupt line are 0 while the three level inputs are 0.
- R2: The status bits mirror the level inputs in the same cycle: bit 4 is the transmit role, bit 3 is bus busy (another master holds the bus), and bit 0 is the slave role.
- R3: An own-address match pulse sets the interrupt flag (bit 5) at the next clock edge only while acknowledge-enable is 1. While acknowledge-enable is 0 the pulse changes no status bit.
- R4: A general-call match pulse sets both the general-call flag (bit 7) and the interrupt flag only while both general-call enable and acknowledge-enable are 1. Otherwise it changes no status bit.
- R5: A master byte-done pulse sets the interrupt flag even when arbitration is lost in the same cycle. The arbitration-lost pulse sets bit 2.
- R6: A slave byte-done pulse sets the interrupt flag only while the device is addressed. The device becomes addressed when an own-address or general-call match is accepted, and stops being addressed at a stop or a start.
- R7: A stop pulse while addressed sets the stop flag (bit 6) and the interrupt flag, and ends the addressed state. A stop pulse while not addressed changes no status bit.
- R8: An acknowledge-sample pulse loads bit 1 with the sampled value (1 = not acknowledged, 0 = acknowledged). Between pulses, bit 1 holds its value.
- R9: A read strobe clears the interrupt flag at the next edge and leaves every other bit unchanged.
- R10: When a qualifying event and a read strobe fall in the same cycle, the interrupt flag is set after that edge.
- R11: A start pulse clears bits 7, 6 and 2 and ends the addressed state. An accepted own-address match clears bit 7.
- R12: The interrupt line always equals status bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_own_addr_i | input | 1 | Pulse: own slave address received |
| ev_gcall_i | input | 1 | Pulse: general-call address received |
| ev_mst_byte_i | input | 1 | Pulse: byte finished in master role |
| ev_slv_byte_i | input | 1 | Pulse: byte finished in slave role |
| ev_stop_i | input | 1 | Pulse: stop condition seen |
| ev_start_i | input | 1 | Pulse: start condition seen |
| ev_arb_lost_i | input | 1 | Pulse: arbitration lost |
| ev_ack_smp_i | input | 1 | Pulse: acknowledge bit sampled |
| ack_nack_i | input | 1 | Sampled acknowledge value, 1 = not acknowledged |
| lvl_tx_i | input | 1 | Level: engine is transmitting |
| lvl_busy_i | input | 1 | Level: another master holds the bus |
| lvl_slave_i | input | 1 | Level: engine is in slave role |
| cfg_ack_en_i | input | 1 | Configuration: acknowledge enable |
| cfg_gc_en_i | input | 1 | Configuration: general-call enable |
| stat_rd_i | input | 1 | Pulse: host reads the status word |
| stat_o | output | 8 | Status word |
| irq_o | output | 1 | Level interrupt request |

## Verification
If the addressed-slave record is wrong, the fault appears one cycle after the next slave byte or stop pulse. Bit 5, or bit 6, comes up when it should stay low, or stays low when it should come up. A wrong priority between set and clear in a flag cell shows at the edge after a read or a start that coincides with an event. For that reason the directed tests drive those collisions and read the whole word one cycle later. A sticky flag that drops or holds too long differs in the next word read, because every scenario compares all eight bits and the interrupt line after each pulse.

// File: rtl/twi_stat_pkg.sv
package twi_stat_pkg;
   localparam int STAT_BITS   = 8;
   // status word bit positions (host software decodes these)
   localparam int B_GCALL     = 7;
   localparam int B_STOP      = 6;
   localparam int B_IRQ       = 5;
   localparam int B_TX        = 4;
   localparam int B_BUSY      = 3;
   localparam int B_ARB       = 2;
   localparam int B_NACK      = 1;
   localparam int B_SLAVE     = 0;
   // sticky flag bank layout
   localparam int N_STICKY    = 3;
   localparam int S_GCALL     = 0;
   localparam int S_STOP      = 1;
   localparam int S_ARB       = 2;

   typedef struct packed {
      logic irq_set;
      logic gc_set;
      logic gc_clr;
      logic stop_set;
      logic phase_clr;
   } twi_qual_t;
endpackage

// File: rtl/twi_flag_cell.sv
module twi_flag_cell #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic nxt;

   generate
      if (SET_WINS) begin : g_set_wins
         assign nxt = set_i | (q_o & ~clr_i);
      end else begin : g_clr_wins
         assign nxt = (q_o | set_i) & ~clr_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= nxt;
   end
endmodule

// File: rtl/twi_evt_qual.sv
module twi_evt_qual
   import twi_stat_pkg::*;
#(
   parameter bit GC_ENABLE = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ev_own_addr_i,
   input  logic      ev_gcall_i,
   input  logic      ev_mst_byte_i,
   input  logic      ev_slv_byte_i,
   input  logic      ev_stop_i,
   input  logic      ev_start_i,
   input  logic      cfg_ack_en_i,
   input  logic      cfg_gc_en_i,
   output twi_qual_t qual_o
);
   logic own_ok;
   logic gc_ok;
   logic addressed_q;
   logic stop_ok;
   logic slv_ok;

   assign own_ok = ev_own_addr_i & cfg_ack_en_i;

   generate
      if (GC_ENABLE) begin : g_gc
         assign gc_ok = ev_gcall_i & cfg_gc_en_i & cfg_ack_en_i;
      end else begin : g_no_gc
         assign gc_ok = 1'b0;
      end
   endgenerate

   // addressed-slave record: opened by an accepted match, closed by stop/start
   twi_flag_cell #(.SET_WINS(1'b1)) u_addressed (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (own_ok | gc_ok),
      .clr_i (ev_stop_i | ev_start_i),
      .q_o   (addressed_q)
   );

   assign stop_ok = ev_stop_i & addressed_q;
   assign slv_ok  = ev_slv_byte_i & addressed_q;

   always_comb begin
      qual_o           = '0;
      qual_o.irq_set   = own_ok | gc_ok | ev_mst_byte_i | slv_ok | stop_ok;
      qual_o.gc_set    = gc_ok;
      qual_o.gc_clr    = own_ok | ev_start_i;
      qual_o.stop_set  = stop_ok;
      qual_o.phase_clr = ev_start_i;
   end
endmodule

// File: rtl/twi_sticky_bank.sv
module twi_sticky_bank
   import twi_stat_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  twi_qual_t           qual_i,
   input  logic                ev_arb_lost_i,
   input  logic                ev_ack_smp_i,
   input  logic                ack_nack_i,
   output logic [N_STICKY-1:0] sticky_o,
   output logic                nack_o
);
   logic [N_STICKY-1:0] set_v;
   logic [N_STICKY-1:0] clr_v;

   always_comb begin
      set_v          = '0;
      clr_v          = '0;
      set_v[S_GCALL] = qual_i.gc_set;
      clr_v[S_GCALL] = qual_i.gc_clr;
      set_v[S_STOP]  = qual_i.stop_set;
      clr_v[S_STOP]  = qual_i.phase_clr;
      set_v[S_ARB]   = ev_arb_lost_i;
      clr_v[S_ARB]   = qual_i.phase_clr;
   end

   generate
      for (genvar i = 0; i < N_STICKY; i++) begin : g_cell
         twi_flag_cell #(.SET_WINS(1'b1)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v[i]),
            .clr_i (clr_v[i]),
            .q_o   (sticky_o[i])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            nack_o <= 1'b0;
      else if (ev_ack_smp_i) nack_o <= ack_nack_i;
   end
endmodule

// File: rtl/twi_status_flags.sv
module twi_status_flags
   import twi_stat_pkg::*;
#(
   parameter int STAT_W    = 8,
   parameter bit GC_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_own_addr_i,
   input  logic              ev_gcall_i,
   input  logic              ev_mst_byte_i,
   input  logic              ev_slv_byte_i,
   input  logic              ev_stop_i,
   input  logic              ev_start_i,
   input  logic              ev_arb_lost_i,
   input  logic              ev_ack_smp_i,
   input  logic              ack_nack_i,
   input  logic              lvl_tx_i,
   input  logic              lvl_busy_i,
   input  logic              lvl_slave_i,
   input  logic              cfg_ack_en_i,
   input  logic              cfg_gc_en_i,
   input  logic              stat_rd_i,
   output logic [STAT_W-1:0] stat_o,
   output logic              irq_o
);
   generate
      if (STAT_W != STAT_BITS) begin : g_bad_width
         $error("twi_status_flags: STAT_W must equal the fixed status layout width");
      end
   endgenerate

   twi_qual_t           qual;
   logic [N_STICKY-1:0] sticky;
   logic                nack_q;
   logic                irq_q;

   twi_evt_qual #(.GC_ENABLE(GC_ENABLE)) u_qual (
      .clk           (clk),
      .rst_n         (rst_n),
      .ev_own_addr_i (ev_own_addr_i),
      .ev_gcall_i    (ev_gcall_i),
      .ev_mst_byte_i (ev_mst_byte_i),
      .ev_slv_byte_i (ev_slv_byte_i),
      .ev_stop_i     (ev_stop_i),
      .ev_start_i    (ev_start_i),
      .cfg_ack_en_i  (cfg_ack_en_i),
      .cfg_gc_en_i   (cfg_gc_en_i),
      .qual_o        (qual)
   );

   twi_sticky_bank u_sticky (
      .clk           (clk),
      .rst_n         (rst_n),
      .qual_i        (qual),
      .ev_arb_lost_i (ev_arb_lost_i),
      .ev_ack_smp_i  (ev_ack_smp_i),
      .ack_nack_i    (ack_nack_i),
      .sticky_o      (sticky),
      .nack_o        (nack_q)
   );

   // a new event on a read cycle must survive: set beats clear
   twi_flag_cell #(.SET_WINS(1'b1)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (qual.irq_set),
      .clr_i (stat_rd_i),
      .q_o   (irq_q)
   );

   always_comb begin
      stat_o          = '0;
      stat_o[B_GCALL] = sticky[S_GCALL];
      stat_o[B_STOP]  = sticky[S_STOP];
      stat_o[B_IRQ]   = irq_q;
      stat_o[B_TX]    = lvl_tx_i;
      stat_o[B_BUSY]  = lvl_busy_i;
      stat_o[B_ARB]   = sticky[S_ARB];
      stat_o[B_NACK]  = nack_q;
      stat_o[B_SLAVE] = lvl_slave_i;
   end

   assign irq_o = irq_q;
endmodule

module twi_status_flags_chk #(
   parameter int STAT_W    = 8,
   parameter bit GC_ENABLE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ev_own_addr_i,
   input logic              ev_gcall_i,
   input logic              ev_mst_byte_i,
   input logic              ev_slv_byte_i,
   input logic              ev_stop_i,
   input logic              ev_start_i,
   input logic              ev_arb_lost_i,
   input logic              ev_ack_smp_i,
   input logic              ack_nack_i,
   input logic              cfg_ack_en_i,
   input logic              cfg_gc_en_i,
   input logic              stat_rd_i,
   input logic [STAT_W-1:0] stat_o
);
   logic any_ev;
   assign any_ev = ev_own_addr_i | ev_gcall_i | ev_mst_byte_i | ev_slv_byte_i | ev_stop_i;

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (stat_o[7:5] == 3'b000 && stat_o[2:1] == 2'b00));

   assert_own_match_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_own_addr_i && cfg_ack_en_i) |=> stat_o[5]);

   assert_gcall_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (GC_ENABLE && ev_gcall_i && cfg_gc_en_i && cfg_ack_en_i) |=> (stat_o[7] && stat_o[5]));

   assert_master_byte_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_mst_byte_i |=> stat_o[5]);

   assert_arb_lost_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ev_arb_lost_i |=> stat_o[2]);

   assert_nack_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ack_smp_i |=> (stat_o[1] == $past(ack_nack_i)));

   assert_nack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ev_ack_smp_i |=> $stable(stat_o[1]));

   assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd_i && !any_ev) |=> !stat_o[5]);

   assert_read_collide_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd_i && ev_mst_byte_i) |=> stat_o[5]);

   assert_start_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_start_i && !ev_gcall_i && !ev_stop_i && !ev_arb_lost_i)
      |=> (!stat_o[7] && !stat_o[6] && !stat_o[2]));
endmodule

bind twi_status_flags twi_status_flags_chk #(.STAT_W(STAT_W), .GC_ENABLE(GC_ENABLE)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ev_own_addr_i (ev_own_addr_i),
   .ev_gcall_i    (ev_gcall_i),
   .ev_mst_byte_i (ev_mst_byte_i),
   .ev_slv_byte_i (ev_slv_byte_i),
   .ev_stop_i     (ev_stop_i),
   .ev_start_i    (ev_start_i),
   .ev_arb_lost_i (ev_arb_lost_i),
   .ev_ack_smp_i  (ev_ack_smp_i),
   .ack_nack_i    (ack_nack_i),
   .cfg_ack_en_i  (cfg_ack_en_i),
   .cfg_gc_en_i   (cfg_gc_en_i),
   .stat_rd_i     (stat_rd_i),
   .stat_o        (stat_o)
);

// File: tb/tb_twi_status_flags.sv
module tb_twi_status_flags;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       ev_own_addr_i, ev_gcall_i, ev_mst_byte_i, ev_slv_byte_i;
   logic       ev_stop_i, ev_start_i, ev_arb_lost_i, ev_ack_smp_i, ack_nack_i;
   logic       lvl_tx_i, lvl_busy_i, lvl_slave_i;
   logic       cfg_ack_en_i, cfg_gc_en_i, stat_rd_i;
   logic [7:0] stat_o;
   logic       irq_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   twi_status_flags dut (
      .clk(clk), .rst_n(rst_n),
      .ev_own_addr_i(ev_own_addr_i), .ev_gcall_i(ev_gcall_i),
      .ev_mst_byte_i(ev_mst_byte_i), .ev_slv_byte_i(ev_slv_byte_i),
      .ev_stop_i(ev_stop_i), .ev_start_i(ev_start_i),
      .ev_arb_lost_i(ev_arb_lost_i), .ev_ack_smp_i(ev_ack_smp_i),
      .ack_nack_i(ack_nack_i), .lvl_tx_i(lvl_tx_i), .lvl_busy_i(lvl_busy_i),
      .lvl_slave_i(lvl_slave_i), .cfg_ack_en_i(cfg_ack_en_i),
      .cfg_gc_en_i(cfg_gc_en_i), .stat_rd_i(stat_rd_i),
      .stat_o(stat_o), .irq_o(irq_o)
   );

   // event mask: 0 own, 1 gcall, 2 master byte, 3 slave byte, 4 stop, 5 arb lost, 6 start
   task automatic drive_ev(input logic [6:0] m);
      ev_own_addr_i = m[0];
      ev_gcall_i    = m[1];
      ev_mst_byte_i = m[2];
      ev_slv_byte_i = m[3];
      ev_stop_i     = m[4];
      ev_arb_lost_i = m[5];
      ev_start_i    = m[6];
   endtask

   task automatic chk(input string req, input logic [7:0] exp);
      #1;
      checks++;
      if (stat_o !== exp) begin
         errors++;
         $display("FAIL %s stat_o=%02h expected %02h", req, stat_o, exp);
      end
      checks++;
      if (irq_o !== exp[5]) begin
         errors++;
         $display("FAIL R12 (%s) irq_o=%b expected %b", req, irq_o, exp[5]);
      end
   endtask

   task automatic pulse(input logic [6:0] m);
      @(negedge clk); drive_ev(m);
      @(negedge clk); drive_ev(7'd0);
   endtask

   task automatic ack_pulse(input logic nack);
      @(negedge clk); ev_ack_smp_i = 1'b1; ack_nack_i = nack;
      @(negedge clk); ev_ack_smp_i = 1'b0;
   endtask

   task automatic rd_pulse();
      @(negedge clk); stat_rd_i = 1'b1;
      @(negedge clk); stat_rd_i = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      drive_ev(7'd0);
      ev_ack_smp_i = 0; ack_nack_i = 0; stat_rd_i = 0;
      lvl_tx_i = 0; lvl_busy_i = 0; lvl_slave_i = 0;
      cfg_ack_en_i = 0; cfg_gc_en_i = 0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_r1();
      do_reset();
      chk("R1 reset", 8'h00);
   endtask

   task automatic t_levels_r2();
      do_reset();
      @(negedge clk); lvl_tx_i = 1; lvl_busy_i = 0; lvl_slave_i = 1;
      chk("R2 tx+slave", 8'h11);
      @(negedge clk); lvl_tx_i = 0; lvl_busy_i = 1; lvl_slave_i = 0;
      chk("R2 busy", 8'h08);
      @(negedge clk); lvl_busy_i = 0;
   endtask

   task automatic t_own_r3();
      do_reset();
      cfg_ack_en_i = 0; pulse(7'b0000001);
      chk("R3 own match ack off", 8'h00);
      cfg_ack_en_i = 1; pulse(7'b0000001);
      chk("R3 own match ack on", 8'h20);
   endtask

   task automatic t_gcall_r4();
      do_reset();
      cfg_gc_en_i = 1; cfg_ack_en_i = 0; pulse(7'b0000010);
      chk("R4 gcall ack off", 8'h00);
      cfg_gc_en_i = 0; cfg_ack_en_i = 1; pulse(7'b0000010);
      chk("R4 gcall gc off", 8'h00);
      cfg_gc_en_i = 1; pulse(7'b0000010);
      chk("R4 gcall accepted", 8'hA0);
   endtask

   task automatic t_master_r5();
      do_reset();
      pulse(7'b0100100);
      chk("R5 master byte with arb lost", 8'h24);
   endtask

   task automatic t_slave_r6();
      do_reset();
      cfg_ack_en_i = 1;
      pulse(7'b0001000);
      chk("R6 slave byte not addressed", 8'h00);
      pulse(7'b0000001);
      chk("R6 address accepted", 8'h20);
      rd_pulse();
      chk("R6 read before byte", 8'h00);
      pulse(7'b0001000);
      chk("R6 slave byte addressed", 8'h20);
   endtask

   task automatic t_stop_r7();
      do_reset();
      cfg_ack_en_i = 1;
      pulse(7'b0010000);
      chk("R7 stop not addressed", 8'h00);
      pulse(7'b0000001);
      rd_pulse();
      chk("R7 addressed idle", 8'h00);
      pulse(7'b0010000);
      chk("R7 stop addressed", 8'h60);
      rd_pulse();
      chk("R7 read after stop", 8'h40);
      pulse(7'b0001000);
      chk("R7 addressing ended by stop", 8'h40);
   endtask

   task automatic t_ack_r8();
      do_reset();
      ack_pulse(1'b1);
      chk("R8 nack sampled", 8'h02);
      @(negedge clk); ack_nack_i = 0;
      @(negedge clk);
      chk("R8 hold between samples", 8'h02);
      ack_pulse(1'b0);
      chk("R8 ack sampled", 8'h00);
   endtask

   task automatic t_read_r9();
      do_reset();
      pulse(7'b0100100);
      ack_pulse(1'b1);
      chk("R9 before read", 8'h26);
      rd_pulse();
      chk("R9 read clears irq only", 8'h06);
   endtask

   task automatic t_collide_r10();
      do_reset();
      pulse(7'b0000100);
      chk("R10 first event", 8'h20);
      @(negedge clk); stat_rd_i = 1; drive_ev(7'b0000100);
      @(negedge clk); stat_rd_i = 0; drive_ev(7'd0);
      chk("R10 event on read cycle kept", 8'h20);
      rd_pulse();
      chk("R10 plain read clears", 8'h00);
   endtask

   task automatic t_start_r11();
      do_reset();
      cfg_gc_en_i = 1; cfg_ack_en_i = 1;
      pulse(7'b0000010);
      pulse(7'b0010000);
      chk("R11 gcall then stop", 8'hE0);
      pulse(7'b0100000);
      rd_pulse();
      chk("R11 sticky before start", 8'hC4);
      pulse(7'b1000000);
      chk("R11 start clears sticky", 8'h00);
      pulse(7'b0000010);
      rd_pulse();
      chk("R11 gcall flag alone", 8'h80);
      pulse(7'b0000001);
      chk("R11 own match clears gcall", 8'h20);
      rd_pulse();
      pulse(7'b1000000);
      pulse(7'b0001000);
      chk("R11 start ends addressing", 8'h00);
   endtask

   initial begin
      rst_n = 1'b0;
      drive_ev(7'd0);
      ev_ack_smp_i = 0; ack_nack_i = 0; stat_rd_i = 0;
      lvl_tx_i = 0; lvl_busy_i = 0; lvl_slave_i = 0;
      cfg_ack_en_i = 0; cfg_gc_en_i = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_r1();
      t_levels_r2();
      t_own_r3();
      t_gcall_r4();
      t_master_r5();
      t_slave_r6();
      t_stop_r7();
      t_ack_r8();
      t_read_r9();
      t_collide_r10();
      t_start_r11();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule